// File: doc/BRIEF.md
# Dual-Mode Underflow Timer

A 16-bit down-counter that runs in one of two modes. In pulse-width mode it steps down once per instruction-clock enable pulse. When it passes zero it reloads, and it inverts its output pin at that moment. Reloads alternate between two reload registers, so the pin's high and low times can differ. In event mode it steps down once per qualifying transition of an external input instead. The input is synchronised first, and a control bit chooses rising or falling transitions. In event mode the count may rest at zero. The underflow only happens on the next qualifying transition, so a load of N-1 signals after N events and a load of all ones just counts freely.

Every underflow raises a pending flag. The interrupt line is driven only while that flag, a local timer enable and a global enable input are all high. Software controls everything through one write port. A control state machine has three states: `ST_STOP` (halted, count frozen), `ST_PWM` (ticking on the instruction clock) and `ST_EVT` (ticking on input edges). Every transition between states is taken on a control-register write. Run=0 leads to `ST_STOP`, run=1 with the event bit set leads to `ST_EVT`, and run=1 with it clear leads to `ST_PWM`. No other input moves the state.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the count is 0, the output pin is 0, the pending flag is 0, the interrupt is 0 and the state is `ST_STOP`.
- R2: A write with `wr_addr`=0 loads the count, and the new value is visible in the cycle after the write even while the timer is running. Address 1 writes reload register A and address 2 writes reload register B. Address 4 writes the pin level from data bit 0. Address 3 is control: bit0 run, bit1 event mode, bit2 rising-edge select (0 = falling), bit3 timer interrupt enable, bit4 write 1 to clear pending. The state changes only on a control write.
- R3: In `ST_STOP` the count holds, whatever happens on the tick and external inputs.
- R4: In `ST_PWM` the count decrements on each cycle with `tick`=1. A tick at count 0 is an underflow: the count reloads and the pin inverts. An interval whose start value is V therefore lasts V+1 ticks.
- R5: Pulse-width reloads alternate between the two registers, and reset points the selector at reload register A. So after reset the pin intervals are (start+1), (A+1), (B+1), (A+1) ticks, beginning at the level that was written.
- R6: Every underflow sets pending. A control write with bit4 set clears it, but an underflow in the same cycle keeps it set.
- R7: `irq` is high exactly when pending, the timer interrupt enable and `glb_ie` are all high.
- R8: In `ST_EVT` the count moves only on the selected transition of `ext_in`, seen after a two-flop synchroniser, and `tick` has no effect. A detected edge lasts one cycle, so at most one step happens per two cycles.
- R9: In `ST_EVT` the count rests at 0 until one more qualifying edge arrives. That edge is the underflow: it reloads from register A and leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-clock enable pulse |
| ext_in | input | 1 | External event input (asynchronous) |
| glb_ie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| tmr_out | output | 1 | Toggling timer output pin |
| pend | output | 1 | Pending flag |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle:
- the state changes only on control writes;
- the count is frozen when stopped, and in event mode it is frozen in cycles without an edge;
- an edge pulse is never followed by another of the same polarity;
- an underflow always sets pending;
- a pulse-width underflow flips the pin and loads the currently selected reload register;
- event mode never moves the pin.

Only the bench scenarios show the following:
- the alternating high/low interval lengths measured across swept reload values and tick rates;
- the count-N-events behaviour and the rest at zero;
- the free-running count from all ones;
- the clear-versus-underflow collision;
- the three-input interrupt gating.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_PWM  = 2'd1,
        ST_EVT  = 2'd2
    } run_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_RLA = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLB = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_LVL = 3'd4;

    localparam int B_RUN  = 0;
    localparam int B_EVT  = 1;
    localparam int B_RISE = 2;
    localparam int B_IEN  = 3;
    localparam int B_CLR  = 4;
endpackage

// File: rtl/dmt_edge_sync.sv
module dmt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise,
    output logic edge_o
);
    localparam int TOP = STAGES;

    // sh[STAGES-1] is the synchronised sample, sh[STAGES] the previous one
    logic [TOP:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[TOP-1:0], din};
    end

    always_comb begin
        if (rise) edge_o = sh[TOP-1] & ~sh[TOP];
        else      edge_o = ~sh[TOP-1] & sh[TOP];
    end

    // R8: an edge of one polarity cannot repeat in the next cycle
    assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (!edge_o || rise != $past(rise)));
endmodule

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
    import dmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       run,
    input  logic       evt_mode,
    input  logic       tick,
    input  logic       edge_i,
    output run_state_e state,
    output logic       dec
);
    run_state_e nxt;

    always_comb begin
        nxt = state;
        if (ctl_wr) begin
            if (!run)         nxt = ST_STOP;
            else if (evt_mode) nxt = ST_EVT;
            else              nxt = ST_PWM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_STOP: dec = 1'b0;
            ST_PWM:  dec = tick;
            ST_EVT:  dec = edge_i;
            default: dec = 1'b0;
        endcase
    end

    // R2: only a control write moves the state
    assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> state == $past(state));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ext_in,
    input  logic              glb_ie,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  count,
    output logic              tmr_out,
    output logic              pend,
    output logic              irq
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] cnt_q, rld_a, rld_b, rld_val;
    logic             sel_q, ien_q, rise_q, out_q, pend_q;
    logic             cnt_wr, ctl_wr, lvl_wr, rla_wr, rlb_wr;
    logic             edge_s, dec, uf, pwm_act;
    run_state_e       state;

    assign cnt_wr = wr_en && wr_addr == A_CNT;
    assign rla_wr = wr_en && wr_addr == A_RLA;
    assign rlb_wr = wr_en && wr_addr == A_RLB;
    assign ctl_wr = wr_en && wr_addr == A_CTL;
    assign lvl_wr = wr_en && wr_addr == A_LVL;

    dmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_in), .rise(rise_q), .edge_o(edge_s)
    );

    dmt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .run(wr_data[B_RUN]), .evt_mode(wr_data[B_EVT]),
        .tick(tick), .edge_i(edge_s), .state(state), .dec(dec)
    );

    assign pwm_act = state == ST_PWM;
    assign uf      = dec && cnt_q == ZERO;
    assign rld_val = (pwm_act && sel_q) ? rld_b : rld_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_a  <= '0;
            rld_b  <= '0;
            ien_q  <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            if (rla_wr) rld_a <= wr_data;
            if (rlb_wr) rld_b <= wr_data;
            if (ctl_wr) begin
                ien_q  <= wr_data[B_IEN];
                rise_q <= wr_data[B_RISE];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sel_q  <= 1'b0;
            out_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cnt_wr)   cnt_q <= wr_data;
            else if (uf)  cnt_q <= rld_val;
            else if (dec) cnt_q <= cnt_q - 1'b1;

            if (uf && pwm_act) sel_q <= ~sel_q;

            if (lvl_wr)             out_q <= wr_data[0];
            else if (uf && pwm_act) out_q <= ~out_q;

            if (uf)                            pend_q <= 1'b1;
            else if (ctl_wr && wr_data[B_CLR]) pend_q <= 1'b0;
        end
    end

    assign count   = cnt_q;
    assign tmr_out = out_q;
    assign pend    = pend_q;
    assign irq     = pend_q & ien_q & glb_ie;

    assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> pend);
    assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && pwm_act && !lvl_wr) |=> tmr_out != $past(tmr_out));
    assert_reload_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && pwm_act && !cnt_wr) |=> count == ($past(sel_q) ? $past(rld_b) : $past(rld_a)));
    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !cnt_wr) |=> count == $past(count));
    assert_evt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVT && !edge_s && !cnt_wr) |=> count == $past(count));
    assert_evt_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVT && !lvl_wr) |=> tmr_out == $past(tmr_out));
endmodule

// File: tb/dual_mode_timer_bench.sv
`timescale 1ns/1ps
module dual_mode_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ext_in = 1'b0;
    logic        glb_ie = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        tmr_out, pend, irq;

    int checks = 0;
    int errors = 0;
    int div = 1;
    int ph = 0;
    bit tick_on = 1'b0;

    dual_mode_timer u_dual_mode_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_in(ext_in), .glb_ie(glb_ie),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .tmr_out(tmr_out), .pend(pend), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (!tick_on) begin
            tick <= 1'b0;
            ph <= 0;
        end else begin
            tick <= (ph == 0);
            ph <= (ph + 1 >= div) ? 0 : ph + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse();
        ext_in = 1'b1;
        repeat (4) @(negedge clk);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(output int d[4]);
        logic cur = tmr_out;
        int len = 1;
        int k = 0;
        int guard = 0;
        d = '{0, 0, 0, 0};
        while (k < 4 && guard < 500) begin
            @(negedge clk);
            guard++;
            if (tmr_out === cur) len++;
            else begin
                d[k] = len; k++; cur = tmr_out; len = 1;
            end
        end
    endtask

    // control word: bit0 run, bit1 event, bit2 rising, bit3 ien, bit4 clear
    initial begin
        int vals[4] = '{0, 1, 2, 5};
        int d[4];
        repeat (2) @(negedge clk);
        chk("R1 count", count, 0);
        chk("R1 out", tmr_out, 0);
        chk("R1 pend", pend, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: stopped counter holds under ticks and edges
        wr(3'd0, 16'd77);
        chk("R2 count write", count, 77);
        tick_on = 1'b1; div = 1;
        pulse(); pulse();
        chk("R3 stop hold", count, 77);

        // R4/R5: pulse-width sweep at full tick rate
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                do_reset();
                tick_on = 1'b1; div = 1;
                wr(3'd1, 16'(vals[i]));
                wr(3'd2, 16'(vals[j]));
                wr(3'd0, 16'd2);
                wr(3'd4, 16'd1);
                wr(3'd3, 16'h0001);
                chk("R4 start level", tmr_out, 1);
                measure(d);
                chk("R4 first interval", d[0], 3);
                chk("R5 interval A", d[1], vals[i] + 1);
                chk("R5 interval B", d[2], vals[j] + 1);
                chk("R5 interval A again", d[3], vals[i] + 1);
            end
        end

        // R5 at a divided tick rate, starting low
        for (int dv = 2; dv <= 4; dv++) begin
            do_reset();
            tick_on = 1'b1; div = dv;
            wr(3'd1, 16'd3);
            wr(3'd2, 16'd1);
            wr(3'd0, 16'd0);
            wr(3'd4, 16'd0);
            wr(3'd3, 16'h0001);
            chk("R4 start level low", tmr_out, 0);
            measure(d);
            chk("R5 div interval A", d[1], 4 * dv);
            chk("R5 div interval B", d[2], 2 * dv);
            chk("R5 div interval A again", d[3], 4 * dv);
        end

        // R2: count write takes effect while running
        wr(3'd0, 16'd100);
        chk("R2 running count write", count, 100);

        // R7: interrupt gating (pend is set from the runs above)
        wr(3'd3, 16'h0000);
        chk("R6 pend set", pend, 1);
        glb_ie = 1'b1;
        @(negedge clk);
        chk("R7 irq ien=0", irq, 0);
        wr(3'd3, 16'h0008);
        glb_ie = 1'b0;
        @(negedge clk);
        chk("R7 irq glb=0", irq, 0);
        glb_ie = 1'b1;
        @(negedge clk);
        chk("R7 irq all set", irq, 1);
        wr(3'd3, 16'h0018);
        chk("R6 clear", pend, 0);
        chk("R7 irq after clear", irq, 0);

        // R6: clear coinciding with an underflow
        do_reset();
        tick_on = 1'b1; div = 1;
        wr(3'd1, 16'd50);
        wr(3'd0, 16'd1);
        wr(3'd3, 16'h0001);
        wr(3'd3, 16'h0011);
        chk("R6 underflow wins over clear", pend, 1);
        wr(3'd3, 16'h0010);
        chk("R6 clear when stopped", pend, 0);

        // R8/R9: event counting of N falling edges, ticks disabled
        for (int n = 1; n <= 4; n++) begin
            do_reset();
            tick_on = 1'b0;
            glb_ie = 1'b1;
            wr(3'd1, 16'(n - 1));
            wr(3'd0, 16'(n - 1));
            wr(3'd4, 16'd1);
            wr(3'd3, 16'h000B);
            for (int p = 1; p < n; p++) pulse();
            chk("R9 rests at zero", count, 0);
            chk("R9 no underflow yet", pend, 0);
            pulse();
            chk("R9 underflow after N edges", pend, 1);
            chk("R9 reload from A", count, n - 1);
            chk("R9 pin unchanged", tmr_out, 1);
            chk("R7 irq event", irq, 1);
        end

        // R8: rising edges, free-running from all ones, tick ignored
        do_reset();
        tick_on = 1'b1; div = 1;
        wr(3'd0, 16'hFFFF);
        wr(3'd3, 16'h0007);
        ext_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 rising counted", count, 16'hFFFE);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 falling ignored", count, 16'hFFFE);
        repeat (4) pulse();
        chk("R8 free-running", count, 16'hFFFA);
        chk("R8 no pend", pend, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule